// File: doc/BRIEF.md
# DRAM Bank Size and Memory Map Calculator

This block works out how much system memory is usable from four DRAM banks and turns the result into settings for two address windows. Each bank has an installed size and a configured size. The configured size is a 3-bit code taken from a pair of configuration bytes. A bank contributes the smaller of the two sizes. The four contributions are added together in KB.

The total is then split into two windows. The conventional window covers 0 to 0x9FFFF. The extended window starts at 0x100000 and covers everything above the first megabyte. Software changes the configuration bytes and then pulses a recalculate strobe. One cycle later the window outputs hold the new values and a done pulse marks them valid.

The installed size of each bank is set while reset is held. A single installed-memory figure is shared out across the banks in order. Each bank takes the largest legal size that still fits in what remains.

Top module: `dram_map_calc`

## Requirements
- R1: A 3-bit size code of 0 or 1 means the bank is absent and contributes 0 KB. A code c from 2 to 7 means 1024 << (c − 2) KB, so code 7 is 32768 KB.
- R2: In `cfg_bytes`, bank 0 reads its code from bits 2:0 and bank 1 from bits 6:4. Bank 2 reads bits 10:8 and bank 3 reads bits 14:12. Bits 3, 7, 11 and 15 are ignored.
- R3: Each bank contributes the smaller of its installed size and its decoded configured size.
- R4: `total_kb` is the sum of the four bank contributions. It is 18 bits wide, so the maximum of 131072 KB is held exactly.
- R5: When the total is above 1024 KB, `low_en` and `high_en` are both 1 and `high_len_kb` equals the total minus 1024.
- R6: When the total is exactly 1024 KB, `low_en` is 1, `high_en` is 0 and `high_len_kb` is 0.
- R7: When the total is below 1024 KB, `low_en`, `high_en` and `high_len_kb` are all 0.
- R8: While `rst_n` is low, the installed sizes are loaded from `inst_total_kb`. Going through banks 0 to 3 in order, each bank takes the largest of 1024, 2048, 4096, 8192, 16384 or 32768 KB that does not exceed the remaining amount, or 0 if none fits. That size is then subtracted from the remaining amount. Bank b appears at `bank_inst_kb[16*b +: 16]`.
- R9: A `recalc` sampled high at a clock edge updates `total_kb`, `low_en`, `high_en` and `high_len_kb` at that edge and raises `done` for exactly that one cycle. Without a strobe, changes to `cfg_bytes` leave the outputs unchanged and `done` stays 0.
- R10: During reset `total_kb`, `low_en`, `high_en`, `high_len_kb` and `done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also loads the installed sizes |
| inst_total_kb | input | 18 | Installed memory in KB, sampled during reset |
| cfg_bytes | input | 16 | Two configuration bytes holding the four bank size codes |
| recalc | input | 1 | Recalculate strobe |
| bank_inst_kb | output | 64 | Installed size of each bank in KB, 16 bits per bank |
| total_kb | output | 18 | Usable memory in KB |
| low_en | output | 1 | Conventional window enabled |
| high_en | output | 1 | Extended window enabled |
| high_len_kb | output | 18 | Extended window length in KB |
| done | output | 1 | One-cycle pulse: the outputs are valid |

## Verification
The installed sizes come from a combinational fill that is registered on reset edges. They are therefore stable one cycle after reset is asserted, and the bench reads them at the falling edge after release. The window results and `done` pass through a single register. When `recalc` is driven at one falling edge, the results are due at the next falling edge, after exactly one rising edge. The bench checks every window output there, and then confirms one cycle later that `done` has fallen again. For the ignored-input case, `cfg_bytes` is changed with no strobe and the outputs are sampled over several cycles. Only after that does a strobe expose the new value.

// File: rtl/dmc_pkg.sv
// dmc_pkg: constants and the size-code decode shared by the memory map
// calculator. Assumes a 3-bit code in which the lowest two values mean absent.
package dmc_pkg;
    localparam int unsigned CODE_W       = 3;
    localparam int unsigned ABSENT_CODES = 2;
    localparam int unsigned FIELD_STRIDE = 4;
    localparam int unsigned MIN_KB       = 1024;
    localparam int unsigned NUM_SIZES    = (1 << CODE_W) - ABSENT_CODES;
    localparam int unsigned MAX_KB       = MIN_KB << (NUM_SIZES - 1);
    localparam int unsigned SZ_W         = $clog2(MAX_KB + 1);

    // Turn a size code into KB (absent codes give zero).
    function automatic logic [SZ_W-1:0] decode_kb(input logic [CODE_W-1:0] code);
        if (int'(code) < ABSENT_CODES)
            return '0;
        return SZ_W'(MIN_KB << (int'(code) - ABSENT_CODES));
    endfunction
endpackage

// File: rtl/dmc_bank_fill.sv
// dmc_bank_fill: shares an installed-memory total out across the banks in
// order. Each bank takes the largest legal size that fits in the remainder.
// Assumes the total is held steady while reset is asserted; the result is
// captured only during reset and is held after it.
module dmc_bank_fill
    import dmc_pkg::*;
#(
    parameter int unsigned NBANKS = 4,
    parameter int unsigned TOT_W  = 18
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [TOT_W-1:0]       total_kb,
    output logic [NBANKS*SZ_W-1:0] bank_kb
);
    logic [NBANKS*SZ_W-1:0] fill_c;

    // Greedy walk over the banks, largest fitting size first.
    always_comb begin
        logic [TOT_W-1:0] rem;
        logic [TOT_W-1:0] pick;
        rem    = total_kb;
        fill_c = '0;
        for (int b = 0; b < NBANKS; b++) begin
            pick = '0;
            for (int k = 0; k < NUM_SIZES; k++) begin
                if (rem >= TOT_W'(MIN_KB << k))
                    pick = TOT_W'(MIN_KB << k);
            end
            fill_c[b*SZ_W +: SZ_W] = SZ_W'(pick);
            rem = rem - pick;
        end
    end

    // Capture the installed sizes while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bank_kb <= fill_c;
    end

    for (genvar g = 0; g < NBANKS; g++) begin : g_chk
        // A filled bank is zero or a single power-of-two size.
        assert_fill_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ($countones(bank_kb[g*SZ_W +: SZ_W]) <= 1) &&
            (bank_kb[g*SZ_W +: SZ_W] <= SZ_W'(MAX_KB)));
    end
endmodule

// File: rtl/dmc_bank_clip.sv
// dmc_bank_clip: for each bank, decodes the configured size code and clips it
// to the installed size. Purely combinational; assumes the code fields sit at
// a fixed stride of four bits.
module dmc_bank_clip
    import dmc_pkg::*;
#(
    parameter int unsigned NBANKS = 4,
    parameter int unsigned CFG_W  = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [CFG_W-1:0]       cfg_bytes,
    input  logic [NBANKS*SZ_W-1:0] inst_kb,
    output logic [NBANKS*SZ_W-1:0] clip_kb
);
    for (genvar g = 0; g < NBANKS; g++) begin : g_bank
        logic [CODE_W-1:0] code;
        logic [SZ_W-1:0]   dec;
        logic [SZ_W-1:0]   inst;

        // Pick out the code field and take the smaller of the two sizes.
        always_comb begin
            code = cfg_bytes[g*FIELD_STRIDE +: CODE_W];
            dec  = decode_kb(code);
            inst = inst_kb[g*SZ_W +: SZ_W];
            clip_kb[g*SZ_W +: SZ_W] = (dec < inst) ? dec : inst;
        end

        // The contribution never exceeds either size.
        assert_clip_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (clip_kb[g*SZ_W +: SZ_W] <= inst_kb[g*SZ_W +: SZ_W]) &&
            ((cfg_bytes[g*FIELD_STRIDE +: CODE_W] > 3'd1) ||
             (clip_kb[g*SZ_W +: SZ_W] == '0)));
    end
endmodule

// File: rtl/dmc_window.sv
// dmc_window: adds up the bank contributions and, on the recalculate strobe,
// registers the total and the two window settings with a done pulse.
// Assumes the inputs are stable in the cycle the strobe is sampled.
module dmc_window
    import dmc_pkg::*;
#(
    parameter int unsigned NBANKS = 4,
    parameter int unsigned TOT_W  = 18
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   recalc,
    input  logic [NBANKS*SZ_W-1:0] clip_kb,
    output logic [TOT_W-1:0]       total_kb,
    output logic                   low_en,
    output logic                   high_en,
    output logic [TOT_W-1:0]       high_len_kb,
    output logic                   done
);
    localparam logic [TOT_W-1:0] ONE_MB = TOT_W'(MIN_KB);
    localparam logic [TOT_W-1:0] TOP_KB = TOT_W'(NBANKS * MAX_KB);

    logic [TOT_W-1:0] sum_c;

    // Add the per-bank contributions.
    always_comb begin
        sum_c = '0;
        for (int b = 0; b < NBANKS; b++)
            sum_c = sum_c + TOT_W'(clip_kb[b*SZ_W +: SZ_W]);
    end

    // Register the window settings when the strobe arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            total_kb    <= '0;
            low_en      <= 1'b0;
            high_en     <= 1'b0;
            high_len_kb <= '0;
            done        <= 1'b0;
        end else begin
            done <= recalc;
            if (recalc) begin
                total_kb <= sum_c;
                if (sum_c > ONE_MB) begin
                    low_en      <= 1'b1;
                    high_en     <= 1'b1;
                    high_len_kb <= sum_c - ONE_MB;
                end else if (sum_c == ONE_MB) begin
                    low_en      <= 1'b1;
                    high_en     <= 1'b0;
                    high_len_kb <= '0;
                end else begin
                    low_en      <= 1'b0;
                    high_en     <= 1'b0;
                    high_len_kb <= '0;
                end
            end
        end
    end

    assert_done_after_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        recalc |=> done);
    assert_no_done_without_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !recalc |=> !done);
    assert_hold_without_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(recalc) |-> ($stable(total_kb) && $stable(high_len_kb)));
    assert_high_needs_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        high_en |-> (low_en && (high_len_kb + ONE_MB == total_kb)));
    assert_low_only_exact_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (low_en && !high_en) |-> (total_kb == ONE_MB && high_len_kb == '0));
    assert_off_below_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !low_en |-> (total_kb < ONE_MB && !high_en));
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        total_kb <= TOP_KB);
endmodule

// File: rtl/dram_map_calc.sv
// dram_map_calc: top of the DRAM bank size and memory map calculator.
// Fills the installed bank sizes during reset, clips them to the configured
// sizes, and registers the window settings on the recalculate strobe.
// Assumes an even number of banks with two banks per configuration byte.
module dram_map_calc
    import dmc_pkg::*;
#(
    parameter int unsigned NBANKS = 4,
    localparam int unsigned TOT_W = $clog2(NBANKS * MAX_KB + 1),
    localparam int unsigned CFG_W = ((NBANKS + 1) / 2) * 8,
    localparam int unsigned INST_W = NBANKS * SZ_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TOT_W-1:0]  inst_total_kb,
    input  logic [CFG_W-1:0]  cfg_bytes,
    input  logic              recalc,
    output logic [INST_W-1:0] bank_inst_kb,
    output logic [TOT_W-1:0]  total_kb,
    output logic              low_en,
    output logic              high_en,
    output logic [TOT_W-1:0]  high_len_kb,
    output logic              done
);
    logic [INST_W-1:0] clip_kb;

    dmc_bank_fill #(.NBANKS(NBANKS), .TOT_W(TOT_W)) u_fill (
        .clk      (clk),
        .rst_n    (rst_n),
        .total_kb (inst_total_kb),
        .bank_kb  (bank_inst_kb)
    );

    dmc_bank_clip #(.NBANKS(NBANKS), .CFG_W(CFG_W)) u_clip (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_bytes (cfg_bytes),
        .inst_kb   (bank_inst_kb),
        .clip_kb   (clip_kb)
    );

    dmc_window #(.NBANKS(NBANKS), .TOT_W(TOT_W)) u_win (
        .clk         (clk),
        .rst_n       (rst_n),
        .recalc      (recalc),
        .clip_kb     (clip_kb),
        .total_kb    (total_kb),
        .low_en      (low_en),
        .high_en     (high_en),
        .high_len_kb (high_len_kb),
        .done        (done)
    );
endmodule

// File: tb/sim_dram_map_calc.sv
// Directed bench for dram_map_calc: one task per scenario, each checking its
// own results. Inputs change and outputs are sampled on falling edges.
module sim_dram_map_calc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [17:0] inst_total_kb = '0;
    logic [15:0] cfg_bytes = '0;
    logic        recalc = 1'b0;
    logic [63:0] bank_inst_kb;
    logic [17:0] total_kb;
    logic        low_en;
    logic        high_en;
    logic [17:0] high_len_kb;
    logic        done;

    int n_checks = 0;
    int n_errors = 0;
    longint cur_inst [4];

    always #4 clk = ~clk;

    dram_map_calc u0 (
        .clk(clk), .rst_n(rst_n), .inst_total_kb(inst_total_kb),
        .cfg_bytes(cfg_bytes), .recalc(recalc), .bank_inst_kb(bank_inst_kb),
        .total_kb(total_kb), .low_en(low_en), .high_en(high_en),
        .high_len_kb(high_len_kb), .done(done)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Model of the size code (R1).
    function automatic longint m_decode(input int code);
        return (code < 2) ? 0 : (longint'(1024) << (code - 2));
    endfunction

    // Model of the greedy reset fill (R8).
    task automatic m_fill(input longint tot);
        longint rem = tot;
        for (int b = 0; b < 4; b++) begin
            longint pick = 0;
            for (int k = 0; k < 6; k++)
                if (rem >= (longint'(1024) << k)) pick = longint'(1024) << k;
            cur_inst[b] = pick;
            rem -= pick;
        end
    endtask

    function automatic longint m_total(input logic [15:0] cfg);
        longint t = 0;
        for (int b = 0; b < 4; b++) begin
            longint d = m_decode(int'(cfg[b*4 +: 3]));
            t += (d < cur_inst[b]) ? d : cur_inst[b];
        end
        return t;
    endfunction

    // Reset with an installed total; check the reset state and the fill (R8, R10).
    task automatic t_reset(input longint tot);
        @(negedge clk);
        rst_n = 1'b0;
        inst_total_kb = 18'(tot);
        recalc = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R10", "done in reset", longint'(done), 0);
        check("R10", "total in reset", longint'(total_kb), 0);
        check("R10", "windows in reset", longint'({low_en, high_en}), 0);
        check("R10", "high_len in reset", longint'(high_len_kb), 0);
        rst_n = 1'b1;
        m_fill(tot);
        @(negedge clk);
        for (int b = 0; b < 4; b++)
            check("R8", $sformatf("bank%0d installed", b),
                  longint'(bank_inst_kb[b*16 +: 16]), cur_inst[b]);
    endtask

    // Strobe a configuration and check the windows one cycle later (R3-R7, R9).
    task automatic t_apply(input logic [15:0] cfg, input string req);
        longint t;
        @(negedge clk);
        cfg_bytes = cfg;
        recalc = 1'b1;
        @(negedge clk);
        recalc = 1'b0;
        t = m_total(cfg);
        check("R9", "done pulse", longint'(done), 1);
        check(req, "total_kb", longint'(total_kb), t);
        check(req, "low_en", longint'(low_en), (t >= 1024) ? 1 : 0);
        check(req, "high_en", longint'(high_en), (t > 1024) ? 1 : 0);
        check(req, "high_len_kb", longint'(high_len_kb), (t > 1024) ? t - 1024 : 0);
        @(negedge clk);
        check("R9", "done falls", longint'(done), 0);
    endtask

    // Change configuration without a strobe: outputs must hold (R9, R2).
    task automatic t_no_strobe(input logic [15:0] cfg);
        longint t0 = longint'(total_kb);
        longint h0 = longint'(high_len_kb);
        @(negedge clk);
        cfg_bytes = cfg;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R9", "no done without strobe", longint'(done), 0);
        end
        check("R9", "total held", longint'(total_kb), t0);
        check("R9", "high_len held", longint'(high_len_kb), h0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : main
        // 8 MB in one bank; configured 8 MB everywhere (R3, R5).
        t_reset(8192);
        t_apply(16'h5555, "R5");
        // Configured 32 MB clips to 8 MB installed (R3).
        t_apply(16'h0007, "R3");
        // Mixed fill 4 MB + 1 MB; swap codes to exercise clipping both ways (R1, R3).
        t_reset(5120);
        t_apply(16'h0027, "R3");
        t_apply(16'h0072, "R3");
        // Field positions: bits 3 and 7 ignored, bank1 field distinct (R2).
        t_apply(16'h88A8, "R2");
        // Exactly 1 MB (R6).
        t_reset(1024);
        t_apply(16'h0002, "R6");
        // Absent codes 0 and 1 give zero (R1, R7).
        t_apply(16'h1111, "R1");
        t_apply(16'h0000, "R7");
        // Below 1 MB installed: nothing fills (R7, R8).
        t_reset(700);
        t_apply(16'h7777, "R7");
        // Full capacity: 4 x 32 MB (R4).
        t_reset(131072);
        t_apply(16'h7777, "R4");
        // Bank 2 and 3 fields in the second byte only (R2).
        t_apply(16'h7700, "R2");
        // Greedy remainder into the last bank (R8).
        t_reset(100000);
        t_apply(16'h7777, "R4");
        // Configuration change without strobe is ignored until strobed (R9).
        t_no_strobe(16'h2222);
        t_apply(16'h2222, "R5");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule